// File: doc/BRIEF.md
# Keyed IO Delay Configuration Bank

This block is a memory-mapped bank of 32-bit registers that holds the delay element settings of a large number of IO pins. Software reaches it through a simple single-cycle read/write port with byte addresses and a word stride. The bank holds three configuration words per pin, a 16-bit key register that opens and closes the whole per-pin region, and three calibration words. The calibration words are read-only on the bus and are loaded from a separate preload port, which is where a calibration engine would deposit its measured counts.

A write to a per-pin word is honoured only when three conditions hold together: the region has been opened with the correct key, the written word carries the expected signature in its signature field, and the word being replaced does not already have its lock bit set. A word written with the lock bit set therefore freezes itself until the next reset. The coarse and fine element counts of every stored word are driven out continuously, so the delay lines of each pin can be steered directly from the bank.

Top module: `iodly_keyed_bank`

## Requirements
- R1: After reset the key register reads 0x0000AAAB (region closed), every per-pin word reads 0 with its lock bit clear, the calibration words read 0 and both count outputs are all zeros.
- R2: A write to byte address 0x2C stores its low 16 bits in the key register; the region is open only while that register holds 0xAAAA, so writing 0xAAAB or any other value closes it. A read of 0x2C returns the key in bits 15:0 and zeros above.
- R3: A per-pin word keeps the whole written value; its fields are signature bits 17:12, lock bit 10, coarse count bits 9:5 and fine count bits 4:0. For slot s, `delayCoarse[5*s +: 5]` and `delayFine[5*s +: 5]` show the stored coarse and fine counts from the cycle after the accepted write.
- R4: A write to a per-pin word is ignored while the region is closed or when its bits 17:12 differ from 0x29.
- R5: Once a per-pin word stores lock bit 10 = 1, every later write to that word is ignored, even with the region open and a correct signature, until reset; words with lock bit 0 stay writable.
- R6: Per-pin words occupy byte addresses 0x30 to 0xD1C; slot s = (address − 0x30)/4 and pin = s/3, so pin p owns slots 3p, 3p+1, 3p+2. Address bits 1:0 are ignored.
- R7: A pulse on `calLoad` captures the three preload values: 0x14 then reads {16'h0, period}, 0x18 reads the coarse word (delay count 31:16, reference count 15:0) and 0x1C the fine word in the same layout. Bus writes to these three addresses have no effect.
- R8: `rdata` presents the addressed value on the cycle after a cycle with `rdEn` high and holds it until the next read; reads return stored contents whether the region is open or closed.
- R9: Addresses above 0xD1C and unassigned addresses below 0x30 read as zero, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the current cycle |
| rdEn | input | 1 | Read strobe for the current cycle |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rdEn` |
| calLoad | input | 1 | Capture the calibration preload values |
| calPeriod | input | 16 | Reference clock period to preload |
| calCoarse | input | 32 | Coarse calibration word to preload |
| calFine | input | 32 | Fine calibration word to preload |
| delayCoarse | output | 4140 | Coarse count of each slot, 5 bits per slot, slot 0 lowest |
| delayFine | output | 4140 | Fine count of each slot, 5 bits per slot, slot 0 lowest |

## Verification
Every result of this bank is one register stage away from its stimulus: a read issued with `rdEn` in one cycle is due on `rdata` after the next rising edge, and an accepted write shows on the count outputs after the same edge that stores it. The bench drives all inputs on the falling edge, lets a monitor note at the rising edge that a read was issued, and compares `rdata` against the head of an expectation queue on the following falling edge. Count outputs are sampled on the falling edge that ends the write, and ignored writes are proven by reading the target back and by comparing the full output vectors with a snapshot taken before the stimulus.

// File: rtl/iodly_pkg.sv
package iodly_pkg;

  // Fixed register locations (byte addresses)
  localparam int unsigned PERIOD_ADDR = 32'h14;
  localparam int unsigned COARSE_ADDR = 32'h18;
  localparam int unsigned FINE_ADDR   = 32'h1C;
  localparam int unsigned KEY_ADDR    = 32'h2C;

  // Key values for the per-pin region
  localparam logic [15:0] KEY_OPEN  = 16'hAAAA;
  localparam logic [15:0] KEY_CLOSE = 16'hAAAB;

  // Per-pin word layout
  localparam int unsigned SIG_LSB    = 12;
  localparam int unsigned SIG_W      = 6;
  localparam logic [5:0]  SIG_VALUE  = 6'h29;
  localparam int unsigned LOCK_BIT   = 10;
  localparam int unsigned COARSE_LSB = 5;
  localparam int unsigned FINE_LSB   = 0;
  localparam int unsigned ELEM_W     = 5;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_PERIOD,
    RD_COARSE,
    RD_FINE,
    RD_KEY,
    RD_SLOT
  } rdSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   wrSlot;
    logic   rdEn;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/iodly_ctrl.sv
module iodly_ctrl
  import iodly_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SLOT_BASE = 32'h30,
  parameter int unsigned NUM_SLOTS = 828,
  parameter int unsigned IDX_W     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-3:0] wordIdx,
  input  logic [SIG_W-1:0]  wrSig,
  input  logic [15:0]       wrKeyData,
  input  logic              slotLocked,
  output strobe_t           stb,
  output logic [IDX_W-1:0]  slotIdx,
  output logic [15:0]       keyValue
);

  localparam int unsigned SLOT_LAST = SLOT_BASE + 4 * (NUM_SLOTS - 1);

  logic [ADDR_W-1:0] wordAddr;
  logic [ADDR_W-1:0] slotOff;
  logic              inSlots;
  logic              isKey;
  logic              sigOk;
  logic              regionOpen;
  logic [15:0]       keyQ;
  rdSel_e            rdSel;

  assign wordAddr = {wordIdx, 2'b00};
  assign slotOff  = wordAddr - ADDR_W'(SLOT_BASE);
  assign slotIdx  = slotOff[IDX_W+1:2];
  assign inSlots  = (wordAddr >= ADDR_W'(SLOT_BASE)) && (wordAddr <= ADDR_W'(SLOT_LAST));
  assign isKey    = (wordAddr == ADDR_W'(KEY_ADDR));
  assign sigOk    = (wrSig == SIG_VALUE);

  // Key register: region open only while the open key is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyQ <= KEY_CLOSE;
    end else if (wrEn && isKey) begin
      keyQ <= wrKeyData;
    end
  end

  assign regionOpen = (keyQ == KEY_OPEN);
  assign keyValue   = keyQ;

  always_comb begin
    if (inSlots)                                 rdSel = RD_SLOT;
    else if (isKey)                              rdSel = RD_KEY;
    else if (wordAddr == ADDR_W'(PERIOD_ADDR))   rdSel = RD_PERIOD;
    else if (wordAddr == ADDR_W'(COARSE_ADDR))   rdSel = RD_COARSE;
    else if (wordAddr == ADDR_W'(FINE_ADDR))     rdSel = RD_FINE;
    else                                         rdSel = RD_ZERO;
  end

  assign stb.wrSlot = wrEn && inSlots && regionOpen && sigOk && !slotLocked;
  assign stb.rdEn   = rdEn;
  assign stb.rdSel  = rdSel;

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isKey && wrKeyData == KEY_OPEN) |=> regionOpen); // R2

  AST_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isKey && wrKeyData != KEY_OPEN) |=> !regionOpen); // R2

  AST_SIG_REQUIRED: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSlot |-> (wrSig == SIG_VALUE)); // R4

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSlot |-> (rdSel == RD_SLOT)); // R9

endmodule

// File: rtl/iodly_datapath.sv
module iodly_datapath
  import iodly_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 828,
  parameter int unsigned IDX_W     = 10
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [IDX_W-1:0]            slotIdx,
  input  logic [31:0]                 wdata,
  input  logic [15:0]                 keyValue,
  input  logic                        calLoad,
  input  logic [15:0]                 calPeriod,
  input  logic [31:0]                 calCoarse,
  input  logic [31:0]                 calFine,
  output logic [31:0]                 rdata,
  output logic                        slotLocked,
  output logic [NUM_SLOTS*ELEM_W-1:0] delayCoarse,
  output logic [NUM_SLOTS*ELEM_W-1:0] delayFine
);

  logic [31:0]      slotMem [NUM_SLOTS];
  logic [IDX_W-1:0] idxSafe;
  logic [15:0]      calPeriodQ;
  logic [31:0]      calCoarseQ;
  logic [31:0]      calFineQ;

  // Keep the index inside the array even for addresses outside the slots
  assign idxSafe    = (slotIdx < IDX_W'(NUM_SLOTS)) ? slotIdx : '0;
  assign slotLocked = slotMem[idxSafe][LOCK_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) slotMem[i] <= '0;
    end else if (stb.wrSlot) begin
      slotMem[idxSafe] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      calPeriodQ <= '0;
      calCoarseQ <= '0;
      calFineQ   <= '0;
    end else if (calLoad) begin
      calPeriodQ <= calPeriod;
      calCoarseQ <= calCoarse;
      calFineQ   <= calFine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (stb.rdEn) begin
      case (stb.rdSel)
        RD_SLOT:   rdata <= slotMem[idxSafe];
        RD_KEY:    rdata <= {16'h0, keyValue};
        RD_PERIOD: rdata <= {16'h0, calPeriodQ};
        RD_COARSE: rdata <= calCoarseQ;
        RD_FINE:   rdata <= calFineQ;
        default:   rdata <= '0;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slotOut
    assign delayCoarse[g*ELEM_W +: ELEM_W] = slotMem[g][COARSE_LSB +: ELEM_W];
    assign delayFine[g*ELEM_W +: ELEM_W]   = slotMem[g][FINE_LSB +: ELEM_W];
  end

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSlot |-> !slotLocked); // R5

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.rdSel == RD_ZERO) |=> (rdata == 32'h0)); // R9

  AST_CAL_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    calLoad |=> (calPeriodQ == $past(calPeriod) && calCoarseQ == $past(calCoarse))); // R7

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.rdEn && !$past(!rstN)) |=> $stable(rdata)); // R8

endmodule

// File: rtl/iodly_keyed_bank.sv
module iodly_keyed_bank
  import iodly_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned NUM_PINS     = 276,
  parameter int unsigned REGS_PER_PIN = 3,
  parameter int unsigned SLOT_BASE    = 32'h30
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         wrEn,
  input  logic                                         rdEn,
  input  logic [ADDR_W-1:0]                            addr,
  input  logic [31:0]                                  wdata,
  output logic [31:0]                                  rdata,
  input  logic                                         calLoad,
  input  logic [15:0]                                  calPeriod,
  input  logic [31:0]                                  calCoarse,
  input  logic [31:0]                                  calFine,
  output logic [NUM_PINS*REGS_PER_PIN*ELEM_W-1:0]      delayCoarse,
  output logic [NUM_PINS*REGS_PER_PIN*ELEM_W-1:0]      delayFine
);

  localparam int unsigned NUM_SLOTS = NUM_PINS * REGS_PER_PIN;
  localparam int unsigned IDX_W     = $clog2(NUM_SLOTS);

  strobe_t          stb;
  logic [IDX_W-1:0] slotIdx;
  logic [15:0]      keyValue;
  logic             slotLocked;

  iodly_ctrl #(
    .ADDR_W    (ADDR_W),
    .SLOT_BASE (SLOT_BASE),
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .wordIdx    (addr[ADDR_W-1:2]),
    .wrSig      (wdata[SIG_LSB +: SIG_W]),
    .wrKeyData  (wdata[15:0]),
    .slotLocked (slotLocked),
    .stb        (stb),
    .slotIdx    (slotIdx),
    .keyValue   (keyValue)
  );

  iodly_datapath #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .slotIdx     (slotIdx),
    .wdata       (wdata),
    .keyValue    (keyValue),
    .calLoad     (calLoad),
    .calPeriod   (calPeriod),
    .calCoarse   (calCoarse),
    .calFine     (calFine),
    .rdata       (rdata),
    .slotLocked  (slotLocked),
    .delayCoarse (delayCoarse),
    .delayFine   (delayFine)
  );

endmodule

// File: tb/iodly_keyed_bank_tb.sv
module iodly_keyed_bank_tb;

  localparam int unsigned NSLOT = 828;
  localparam int unsigned VW    = NSLOT * 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          calLoad = 1'b0;
  logic [15:0]   calPeriod = '0;
  logic [31:0]   calCoarse = '0;
  logic [31:0]   calFine = '0;
  logic [VW-1:0] delayCoarse;
  logic [VW-1:0] delayFine;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] expQ [$];
  string       tagQ [$];
  logic        fire = 1'b0;

  logic [VW-1:0] snapC;
  logic [VW-1:0] snapF;

  always #2.5 clk = ~clk;

  iodly_keyed_bank u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .calLoad(calLoad), .calPeriod(calPeriod),
    .calCoarse(calCoarse), .calFine(calFine),
    .delayCoarse(delayCoarse), .delayFine(delayFine)
  );

  function automatic logic [31:0] mkWord(input logic lk, input logic [4:0] c, input logic [4:0] f);
    return 32'h0002_9000 | (32'(lk) << 10) | (32'(c) << 5) | 32'(f);
  endfunction

  task automatic note(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: a read issued at a rising edge is compared on the next falling edge
  always @(posedge clk) fire <= rdEn && rstN;

  always @(negedge clk) begin
    if (fire) begin
      if (expQ.size() == 0) begin
        note(1'b0, "queue underflow", rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        note(rdata === e, t, rdata, e);
      end
    end
  end

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic checkSlot(input int s, input logic [4:0] c, input logic [4:0] f, input string tag);
    note(delayCoarse[s*5 +: 5] === c, {tag, " coarse"}, 32'(delayCoarse[s*5 +: 5]), 32'(c));
    note(delayFine[s*5 +: 5] === f, {tag, " fine"}, 32'(delayFine[s*5 +: 5]), 32'(f));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    applyReset();

    // R1: reset state
    doRead(12'h02C, 32'h0000_AAAB, "R1 key after reset");
    doRead(12'h030, 32'h0, "R1 first slot after reset");
    doRead(12'hD1C, 32'h0, "R1 last slot after reset");
    doRead(12'h014, 32'h0, "R1 period after reset");
    @(negedge clk);
    note(delayCoarse === '0, "R1 coarse outputs zero", 32'(delayCoarse[31:0]), 32'h0);
    note(delayFine === '0, "R1 fine outputs zero", 32'(delayFine[31:0]), 32'h0);

    // R4: closed region ignores a valid write
    doWrite(12'h030, mkWord(1'b0, 5'd3, 5'd7));
    checkSlot(0, 5'd0, 5'd0, "R4 closed region");
    doRead(12'h030, 32'h0, "R4 closed region readback");

    // R2: open the region
    doWrite(12'h02C, 32'hFFFF_AAAA);
    doRead(12'h02C, 32'h0000_AAAA, "R2 open key readback");

    // R4: bad signature ignored
    doWrite(12'h034, (mkWord(1'b0, 5'd4, 5'd4) & ~32'h0003_F000) | 32'h0002_8000);
    doRead(12'h034, 32'h0, "R4 bad signature");

    // R3: accepted write, outputs next cycle
    doWrite(12'h030, mkWord(1'b0, 5'd3, 5'd7));
    checkSlot(0, 5'd3, 5'd7, "R3 slot0 counts");
    doRead(12'h030, 32'h0002_9067, "R3 slot0 readback");

    // R6: pin 1 register 0 is slot 3; last slot; low address bits ignored
    doWrite(12'h03C, mkWord(1'b0, 5'd31, 5'd17));
    checkSlot(3, 5'd31, 5'd17, "R6 pin1 slot3");
    doWrite(12'hD1C, mkWord(1'b0, 5'd5, 5'd2));
    checkSlot(827, 5'd5, 5'd2, "R6 last slot");
    doWrite(12'h036, mkWord(1'b0, 5'd9, 5'd1));
    doRead(12'h034, 32'h0002_9121, "R6 low address bits ignored");
    checkSlot(1, 5'd9, 5'd1, "R6 slot1 counts");

    // R5: sticky lock bit
    doWrite(12'h040, mkWord(1'b1, 5'd2, 5'd1));
    doWrite(12'h040, mkWord(1'b0, 5'd3, 5'd7));
    doRead(12'h040, 32'h0002_9441, "R5 locked word kept");
    checkSlot(4, 5'd2, 5'd1, "R5 locked outputs kept");
    doWrite(12'h030, mkWord(1'b0, 5'd1, 5'd1));
    doRead(12'h030, 32'h0002_9021, "R5 unlocked word rewritable");

    // R2/R4/R8: close region, writes ignored, reads still work
    doWrite(12'h02C, 32'h1234_AAAB);
    doRead(12'h02C, 32'h0000_AAAB, "R2 close key readback");
    doWrite(12'h030, mkWord(1'b0, 5'd31, 5'd31));
    doRead(12'h030, 32'h0002_9021, "R8 read while closed");
    doWrite(12'h02C, 32'h0000_5555);
    doWrite(12'h030, mkWord(1'b0, 5'd31, 5'd31));
    doRead(12'h030, 32'h0002_9021, "R2 other key keeps closed");

    // R7: calibration preload, bus writes ignored
    doWrite(12'h02C, 32'h0000_AAAA);
    @(negedge clk);
    calLoad = 1'b1; calPeriod = 16'h1234; calCoarse = 32'hDEAD_0042; calFine = 32'h0010_0200;
    @(negedge clk);
    calLoad = 1'b0; calPeriod = '0; calCoarse = '0; calFine = '0;
    doRead(12'h014, 32'h0000_1234, "R7 period");
    doRead(12'h018, 32'hDEAD_0042, "R7 coarse calibration");
    doRead(12'h01C, 32'h0010_0200, "R7 fine calibration");
    doWrite(12'h018, mkWord(1'b0, 5'd0, 5'd0));
    doWrite(12'h014, 32'hFFFF_FFFF);
    doRead(12'h018, 32'hDEAD_0042, "R7 coarse bus write ignored");
    doRead(12'h014, 32'h0000_1234, "R7 period bus write ignored");

    // R9: unmapped addresses
    @(negedge clk);
    snapC = delayCoarse; snapF = delayFine;
    doWrite(12'hD20, mkWord(1'b0, 5'd6, 5'd6));
    doWrite(12'hFFC, mkWord(1'b0, 5'd6, 5'd6));
    doWrite(12'h020, mkWord(1'b0, 5'd6, 5'd6));
    note(delayCoarse === snapC, "R9 coarse outputs unchanged", 32'(delayCoarse[31:0]), 32'(snapC[31:0]));
    note(delayFine === snapF, "R9 fine outputs unchanged", 32'(delayFine[31:0]), 32'(snapF[31:0]));
    doRead(12'hD20, 32'h0, "R9 above range");
    doRead(12'hFFC, 32'h0, "R9 top address");
    doRead(12'h000, 32'h0, "R9 offset zero");
    doRead(12'h020, 32'h0, "R9 gap below slots");
    doRead(12'hD1C, 32'h0002_90A2, "R9 last slot intact");

    // R1/R5: reset clears lock bits and reopens only via key
    applyReset();
    doRead(12'h040, 32'h0, "R1 locked word cleared by reset");
    doRead(12'h02C, 32'h0000_AAAB, "R1 key after second reset");
    doWrite(12'h02C, 32'h0000_AAAA);
    doWrite(12'h040, mkWord(1'b0, 5'd3, 5'd7));
    doRead(12'h040, 32'h0002_9067, "R5 writable after reset");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) note(1'b0, "pending reads", 32'(expQ.size()), 32'h0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule